// File: doc/BRIEF.md
# Page Entry Access Checker

This block takes one memory access and the single-level page table entry that maps it. It decides whether the access may go ahead and, if so, gives the physical address. The access arrives as a 32-bit virtual address, an access kind (read, write or instruction fetch) and a privilege flag (user or supervisor). The block registers its result one clock later. The result is a physical address, a fault flag with a two-bit cause, and a copy of the entry with the bookkeeping flags updated. A write-back strobe tells the surrounding table logic that the entry in memory must be rewritten.

Pages are 4 KB. The low twelve address bits pass through as the offset, and the upper twenty bits of the entry give the frame base. Entry bits: 0 = present, 1 = writable, 2 = user allowed, 5 = accessed, 6 = dirty, and bits 31:12 hold the frame. When the present bit is clear, nothing else in the entry has any meaning to the block. The accessed and dirty flags only ever go from 0 to 1 here; clearing them is left to software.

Fault cause codes are 0 = none, 1 = not present, 2 = write to a read-only page, 3 = user access to a supervisor page. Access kind codes are 0 = read, 1 = write, 2 = fetch, 3 = treated as read.

Top module: `pte_access_check`

## Requirements
- R1: While reset is high and on the first cycle after it, rsp_valid, fault and pte_wb are 0 and fault_cause is 0.
- R2: A request taken with req_valid high produces rsp_valid exactly one cycle later. A granted access then has paddr = {pte_in[31:12], vaddr[11:0]}.
- R3: If pte_in bit 0 is 0, the response has fault = 1 and cause 1, whatever the other entry bits, access kind or privilege are.
- R4: A write (kind 1) to a present entry whose bit 1 is 0 faults with cause 2. This cause wins over a privilege violation.
- R5: A user access (is_user = 1) to a present entry whose bit 2 is 0 faults with cause 3. Supervisor accesses ignore bit 2.
- R6: A granted access returns pte_new equal to pte_in with bit 5 set. A granted write also sets bit 6. No other bit changes.
- R7: On a fault, pte_new equals pte_in, paddr is 0 and pte_wb is 0.
- R8: pte_wb is 1 exactly when the access is granted and pte_new differs from pte_in.
- R9: Fetch (kind 2) and kind 3 are checked as reads. They never fault on bit 1 and never set bit 6.
- R10: When req_valid is low, the next cycle shows rsp_valid = 0 and pte_wb = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| is_user | input | 1 | 1 = user mode, 0 = supervisor |
| pte_in | input | 32 | Page table entry mapping the address |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| paddr | output | 32 | Physical address (0 on fault) |
| fault | output | 1 | Access refused |
| fault_cause | output | 2 | 0 none, 1 absent, 2 read-only, 3 privilege |
| pte_new | output | 32 | Entry with flags updated |
| pte_wb | output | 1 | Entry must be written back |

## Verification
The bench targets entries whose present bit is clear but whose other bits are random. A design that looked at those bits would report a protection cause, or strobe a write-back. It sends writes by user code to pages that are both read-only and supervisor-only; swapping the cause priority would report cause 3. It also repeats accesses to entries whose accessed and dirty flags are already set, to catch a strobe raised with no change, and it sends fetches to read-only pages, which a design that decoded fetches as writes would refuse or mark dirty.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

    localparam int ENTRY_W   = 32;
    localparam int OFFSET_W  = 12;
    localparam int FRAME_W   = ENTRY_W - OFFSET_W;

    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER_OK  = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY    = 6;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_SPARE = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_RDONLY = 2'd2,
        CAUSE_PRIV   = 2'd3
    } cause_e;

    typedef struct packed {
        logic present;
        logic writable;
        logic user_ok;
        logic accessed;
        logic dirty;
    } entry_flags_t;

    typedef struct packed {
        logic                 fault;
        cause_e               cause;
        logic [ENTRY_W-1:0]   paddr;
        logic [ENTRY_W-1:0]   entry;
        logic                 wb;
    } check_result_t;

    function automatic logic kind_is_store(acc_kind_e k);
        return k == KIND_WRITE;
    endfunction

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_chk_pkg::*;
(
    input  entry_flags_t flags,
    input  logic         is_store,
    input  logic         is_user,
    output cause_e       cause
);
    always_comb begin
        if (!flags.present)
            cause = CAUSE_ABSENT;
        else if (is_store && !flags.writable)
            cause = CAUSE_RDONLY;
        else if (is_user && !flags.user_ok)
            cause = CAUSE_PRIV;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/pte_flag_merge.sv
module pte_flag_merge
    import pte_chk_pkg::*;
#(
    parameter int W = ENTRY_W
) (
    input  logic [W-1:0] entry_in,
    input  logic         granted,
    input  logic         is_store,
    output logic [W-1:0] entry_out,
    output logic         changed
);
    logic [W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        if (granted) begin
            set_mask[BIT_ACCESSED] = 1'b1;
            set_mask[BIT_DIRTY]    = is_store;
        end
        entry_out = entry_in | set_mask;
        changed   = |(set_mask & ~entry_in);
    end
endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form
    import pte_chk_pkg::*;
#(
    parameter int W   = ENTRY_W,
    parameter int OFF = OFFSET_W
) (
    input  logic [W-1:0]   entry_in,
    input  logic [OFF-1:0] offset,
    input  logic           granted,
    output logic [W-1:0]   paddr
);
    localparam int FW = W - OFF;

    logic [FW-1:0] frame;
    logic [OFF-1:0] unused_entry_low;

    assign frame            = entry_in[W-1:OFF];
    assign unused_entry_low = entry_in[OFF-1:0];
    assign paddr            = granted ? {frame, offset} : '0;
endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
    import pte_chk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ENTRY_W-1:0]  vaddr,
    input  logic [1:0]          acc_kind,
    input  logic                is_user,
    input  logic [ENTRY_W-1:0]  pte_in,
    output logic                rsp_valid,
    output logic [ENTRY_W-1:0]  paddr,
    output logic                fault,
    output logic [1:0]          fault_cause,
    output logic [ENTRY_W-1:0]  pte_new,
    output logic                pte_wb
);
    acc_kind_e     kind;
    entry_flags_t  flags;
    cause_e        cause;
    logic          store;
    logic          granted;
    logic          changed;
    logic [ENTRY_W-1:0] entry_next;
    logic [ENTRY_W-1:0] paddr_next;
    logic [FRAME_W-1:0] unused_vpn;
    check_result_t res_d, res_q;
    logic          valid_q;

    assign unused_vpn = vaddr[ENTRY_W-1:OFFSET_W];
    assign kind       = acc_kind_e'(acc_kind);
    assign store      = kind_is_store(kind);

    assign flags = '{present:  pte_in[BIT_PRESENT],
                     writable: pte_in[BIT_WRITABLE],
                     user_ok:  pte_in[BIT_USER_OK],
                     accessed: pte_in[BIT_ACCESSED],
                     dirty:    pte_in[BIT_DIRTY]};

    pte_perm_eval u_perm (
        .flags    (flags),
        .is_store (store),
        .is_user  (is_user),
        .cause    (cause)
    );

    assign granted = (cause == CAUSE_NONE);

    pte_flag_merge #(.W(ENTRY_W)) u_merge (
        .entry_in  (pte_in),
        .granted   (granted),
        .is_store  (store),
        .entry_out (entry_next),
        .changed   (changed)
    );

    pte_addr_form #(.W(ENTRY_W), .OFF(OFFSET_W)) u_addr (
        .entry_in (pte_in),
        .offset   (vaddr[OFFSET_W-1:0]),
        .granted  (granted),
        .paddr    (paddr_next)
    );

    always_comb begin
        res_d.fault = !granted;
        res_d.cause = cause;
        res_d.paddr = paddr_next;
        res_d.entry = entry_next;
        res_d.wb    = changed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '{fault: 1'b0, cause: CAUSE_NONE, paddr: '0, entry: '0, wb: 1'b0};
        end else begin
            valid_q  <= req_valid;
            res_q.wb <= req_valid && res_d.wb;
            if (req_valid) begin
                res_q.fault <= res_d.fault;
                res_q.cause <= res_d.cause;
                res_q.paddr <= res_d.paddr;
                res_q.entry <= res_d.entry;
            end
        end
    end

    assign rsp_valid   = valid_q;
    assign paddr       = res_q.paddr;
    assign fault       = res_q.fault;
    assign fault_cause = res_q.cause;
    assign pte_new     = res_q.entry;
    assign pte_wb      = res_q.wb;

    // R7, R8: no write-back strobe on a refused access
    a_r7_no_wb_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && fault) |-> !pte_wb);

    // R10: strobe only accompanies a response
    a_r10_wb_needs_rsp: assert property (@(posedge clk) disable iff (rst)
        pte_wb |-> rsp_valid);

    // R6: flags are sticky, the block never clears an entry bit
    a_r6_sticky_bits: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (($past(pte_in) & ~pte_new) == '0));

    // R2: granted result keeps the page offset
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (fault || (paddr[OFFSET_W-1:0] == $past(vaddr[OFFSET_W-1:0]))));

    // R3: absent entry always refused with the absent cause
    a_r3_absent_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pte_in[BIT_PRESENT]) |=> (fault && fault_cause == CAUSE_ABSENT));

    // R9: dirty is newly set only by a write
    a_r9_dirty_only_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pte_in[BIT_DIRTY] && acc_kind != KIND_WRITE) |=> !pte_new[BIT_DIRTY]);

    // R4, R5: fault flag agrees with cause
    a_r4_fault_cause_agree: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (fault == (fault_cause != CAUSE_NONE)));

endmodule

// File: tb/test_pte_access_check.sv
module test_pte_access_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] vaddr;
    logic [1:0]  acc_kind;
    logic        is_user;
    logic [31:0] pte_in;
    logic        rsp_valid;
    logic [31:0] paddr;
    logic        fault;
    logic [1:0]  fault_cause;
    logic [31:0] pte_new;
    logic        pte_wb;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pte_access_check i_pte_access_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
        .acc_kind(acc_kind), .is_user(is_user), .pte_in(pte_in),
        .rsp_valid(rsp_valid), .paddr(paddr), .fault(fault),
        .fault_cause(fault_cause), .pte_new(pte_new), .pte_wb(pte_wb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected cause from the requirements
    function automatic logic [1:0] exp_cause(logic [1:0] k, logic u, logic [31:0] e);
        if (!e[0]) return 2'd1;                 // R3
        if (k == 2'd1 && !e[1]) return 2'd2;    // R4, R9
        if (u && !e[2]) return 2'd3;            // R5
        return 2'd0;
    endfunction

    task automatic access(input logic [31:0] va, input logic [1:0] k,
                          input logic u, input logic [31:0] e, input string tag);
        logic [1:0]  c;
        logic [31:0] ne;
        c  = exp_cause(k, u, e);
        ne = e;
        if (c == 2'd0) begin
            ne[5] = 1'b1;
            if (k == 2'd1) ne[6] = 1'b1;
        end
        req_valid = 1'b1; vaddr = va; acc_kind = k; is_user = u; pte_in = e;
        @(negedge clk);
        check({tag, " R2 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " R3/R4/R5 cause"}, {30'd0, fault_cause}, {30'd0, c});
        check({tag, " R7 fault"}, {31'd0, fault}, {31'd0, c != 2'd0});
        check({tag, " R2/R7 paddr"}, paddr, (c == 2'd0) ? {e[31:12], va[11:0]} : 32'd0);
        check({tag, " R6/R9 pte_new"}, pte_new, ne);
        check({tag, " R8 pte_wb"}, {31'd0, pte_wb}, {31'd0, ne != e});
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; vaddr = '0; acc_kind = '0; is_user = 1'b0; pte_in = '0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 pte_wb in reset", {31'd0, pte_wb}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 fault after reset", {31'd0, fault}, 32'd0);
        check("R1 cause after reset", {30'd0, fault_cause}, 32'd0);

        // directed corners
        access(32'h1234_5ABC, 2'd0, 1'b0, 32'h000A_B007, "R2 sup read");
        access(32'hFFFF_FFFF, 2'd1, 1'b1, 32'hFFFF_FFFE, "R3 absent junk");
        access(32'h0000_0123, 2'd1, 1'b1, 32'h0000_1001, "R4 rdonly beats priv");
        access(32'h0000_0456, 2'd0, 1'b1, 32'h0000_2003, "R5 user on sup page");
        access(32'h0000_0789, 2'd1, 1'b0, 32'h0000_3003, "R5 sup ignores bit2");
        access(32'h0000_0FFF, 2'd1, 1'b1, 32'h8000_0067, "R8 flags already set");
        access(32'h0000_0010, 2'd0, 1'b1, 32'h8000_0027, "R8 accessed already set");
        access(32'h0000_0020, 2'd2, 1'b1, 32'h4000_0005, "R9 fetch rdonly");
        access(32'h0000_0030, 2'd3, 1'b0, 32'h4000_0001, "R9 kind3 rdonly");

        // R10 idle cycle
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        check("R10 pte_wb idle", {31'd0, pte_wb}, 32'd0);

        // constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] e;
            e = $urandom();
            if (($urandom() % 4) != 0) e[0] = 1'b1;
            access($urandom(), 2'($urandom()), 1'($urandom()), e, "rand");
            if (($urandom() % 8) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check("R10 rand idle", {30'd0, rsp_valid, pte_wb}, 32'd0);
            end
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule